// File: doc/BRIEF.md
# DMA Minor-Loop Address Generator

This block produces the read and write addresses for one DMA channel that runs a cyclic transfer. The transfer is made of minor loops. Each minor loop is a fixed number of bytes, moved as a series of accesses. A descriptor is latched when the channel starts. The descriptor holds base addresses for both sides and a signed per-access step for each side. It also holds a 32-bit minor-loop control word, a major iteration count, a signed end-of-buffer adjustment, and a direction flag.

On every access cycle the block asserts its read and write strobes and presents the two current addresses. It then advances each address by its step. At the end of each minor loop, a signed offset packed inside the control word may also be added to either address. This lets a peripheral with two adjacent 32-bit FIFOs be written (or read) alternately and then rewound to the first FIFO.

When the final minor loop of the major loop completes, three things happen. The iteration count reloads. The memory-side address takes the end-of-buffer adjustment, so the ring buffer starts again. A one-cycle done pulse is raised. The channel keeps cycling until it is halted.

Top module: `dma_mloop_agen`

## Requirements
- R1: After reset, `busy`, `rd_strobe`, `wr_strobe` and `major_done` are low.
- R2: A `start` pulse while idle with a nonzero `iter_count` latches the descriptor. From the next cycle, `busy` and both strobes are high, `rd_addr`/`wr_addr` show `src_base`/`dst_base`, and `cur_iter` shows `iter_count`.
- R3: On every access cycle that is not the end of a minor loop, `rd_addr` advances by `src_step` and `wr_addr` advances by `dst_step`. Each step is sign-extended from 16 bits.
- R4: The minor-loop byte count depends on bits 31 and 30 of `mloop_word`. If either bit is set, the count is bits 9:0; if neither is set, it is the whole word. A minor loop takes max(1, ceil(count / ACC_BYTES)) access cycles.
- R5: At the end of a minor loop, the offset in `mloop_word` bits 29:10 is added on top of the per-access step. The offset is signed (bit 29 is its sign). It goes to the write address when bit 30 is set, and to the read address when bit 31 is set.
- R6: `cur_iter` decrements by one at each minor-loop end. When a minor loop ends with `cur_iter` equal to 1, `cur_iter` reloads from the latched count, and `major_done` is high for the next cycle only.
- R7: When the major loop ends, `last_adj` is also added to the memory-side address. That is the read address when `mem_to_dev` is 1, and the write address otherwise.
- R8: Dual-FIFO mode uses a device-side step of 4, a minor-loop offset of -8 with only the device-side enable set, and 8-byte minor loops. In this mode the device address alternates between its base and base+4.
- R9: `start` has no effect while `busy` is high, and none while idle if `iter_count` is zero.
- R10: `halt` during an access cycle returns the block to idle on the next cycle. Both strobes are low and no done pulse is raised.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch descriptor and begin cycling |
| halt | input | 1 | Stop cycling after the current access |
| mem_to_dev | input | 1 | 1: read side is memory; 0: write side is memory |
| src_base | input | 32 | Initial read address |
| dst_base | input | 32 | Initial write address |
| src_step | input | 16 | Signed per-access read step |
| dst_step | input | 16 | Signed per-access write step |
| mloop_word | input | 32 | Byte count, signed minor-loop offset, enables |
| last_adj | input | 32 | Signed memory-side adjustment at major end |
| iter_count | input | CITER_W | Major iteration count |
| rd_strobe | output | 1 | Read access this cycle |
| rd_addr | output | 32 | Current read address |
| wr_strobe | output | 1 | Write access this cycle |
| wr_addr | output | 32 | Current write address |
| major_done | output | 1 | One-cycle pulse after the last minor loop |
| busy | output | 1 | Channel is cycling |
| cur_iter | output | CITER_W | Current iteration count |

## Verification
Every state element is a single register, so each input sampled at a rising edge shows at the outputs one cycle later. The outputs include the addresses, the strobes, `cur_iter` and the done pulse. The bench drives inputs on the falling edge and advances its own reference model once for each rising edge. It compares all outputs on the following falling edge, so the model and the design are always compared for the same access. Directed sequences also check the FIFO alternation, address wrap, ignored starts and halt at those same one-cycle-later points.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  localparam int AW        = 32;
  localparam int OFF_W     = 16;
  localparam int MLOFF_LSB = 10;
  localparam int MLOFF_MSB = 29;
  localparam int MLOFF_W   = MLOFF_MSB - MLOFF_LSB + 1;
  localparam int DST_EN_BIT = 30;
  localparam int SRC_EN_BIT = 31;

  typedef struct packed {
    logic            mem_to_dev;
    logic [OFF_W-1:0] src_step;
    logic [OFF_W-1:0] dst_step;
    logic [AW-1:0]   mloop_word;
    logic [AW-1:0]   last_adj;
  } desc_t;

  function automatic logic [AW-1:0] f_sext_step(input logic [OFF_W-1:0] s);
    return {{(AW-OFF_W){s[OFF_W-1]}}, s};
  endfunction

  function automatic logic [AW-1:0] f_mloff(input logic [AW-1:0] w);
    return {{(AW-MLOFF_W){w[MLOFF_MSB]}}, w[MLOFF_MSB:MLOFF_LSB]};
  endfunction

  function automatic logic f_src_ml_en(input logic [AW-1:0] w);
    return w[SRC_EN_BIT];
  endfunction

  function automatic logic f_dst_ml_en(input logic [AW-1:0] w);
    return w[DST_EN_BIT];
  endfunction

  function automatic logic [AW-1:0] f_minor_bytes(input logic [AW-1:0] w);
    if (w[SRC_EN_BIT] || w[DST_EN_BIT])
      return {{(AW-MLOFF_LSB){1'b0}}, w[MLOFF_LSB-1:0]};
    return w;
  endfunction

  function automatic logic [AW-1:0] f_step_delta(
    input logic [AW-1:0] acc,
    input logic          add_ml,
    input logic [AW-1:0] ml,
    input logic          add_last,
    input logic [AW-1:0] last
  );
    logic [AW-1:0] d;
    d = acc;
    if (add_ml)   d = d + ml;
    if (add_last) d = d + last;
    return d;
  endfunction
endpackage

// File: rtl/agen_loop_ctrl.sv
module agen_loop_ctrl
  import dma_agen_pkg::*;
#(
  parameter int ACC_BYTES = 4,
  parameter int CITER_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               halt,
  input  logic [AW-1:0]      load_bytes,
  input  logic [CITER_W-1:0] load_iter,
  output logic               busy,
  output logic               step,
  output logic               minor_end,
  output logic               major_end,
  output logic               done,
  output logic [CITER_W-1:0] citer
);
  localparam logic [AW-1:0] ACC_W = AW'(ACC_BYTES);
  localparam logic [CITER_W-1:0] ONE = CITER_W'(1);

  logic [AW-1:0]      bytes_q;
  logic [AW-1:0]      left_q;
  logic [CITER_W-1:0] iter_q;

  assign step      = busy && !halt;
  assign minor_end = busy && (left_q <= ACC_W);
  assign major_end = minor_end && (citer == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bytes_q <= '0;
      left_q  <= '0;
      iter_q  <= '0;
      citer   <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      bytes_q <= load_bytes;
      left_q  <= load_bytes;
      iter_q  <= load_iter;
      citer   <= load_iter;
    end else if (busy && halt) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (busy) begin
      done <= major_end;
      if (minor_end) begin
        left_q <= bytes_q;
        citer  <= major_end ? iter_q : citer - ONE;
      end else begin
        left_q <= left_q - ACC_W;
      end
    end else begin
      done <= 1'b0;
    end
  end

  AST_CITER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (citer != '0)); // R6
  AST_MAJOR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && major_end) |=> (citer == iter_q)); // R6
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step && major_end)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !minor_end) |=> (citer == $past(citer))); // R9
endmodule

// File: rtl/agen_addr_unit.sv
module agen_addr_unit
  import dma_agen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic             step,
  input  logic             minor_end,
  input  logic             major_end,
  input  logic [OFF_W-1:0] acc_off,
  input  logic             ml_en,
  input  logic [AW-1:0]    ml_off,
  input  logic             last_en,
  input  logic [AW-1:0]    last_adj,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0] acc_ext;
  logic [AW-1:0] delta;
  logic          add_ml;
  logic          add_last;

  assign acc_ext  = f_sext_step(acc_off);
  assign add_ml   = minor_end && ml_en;
  assign add_last = major_end && last_en;
  assign delta    = f_step_delta(acc_ext, add_ml, ml_off, add_last, last_adj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= addr + delta;
  end

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !minor_end && !load) |=> (addr == $past(addr) + $past(acc_ext))); // R3
  AST_MINOR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && minor_end && !major_end && !load) |=>
      (addr == $past(addr) + $past(acc_ext) + ($past(ml_en) ? $past(ml_off) : '0))); // R5
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(load_addr))); // R2
endmodule

// File: rtl/dma_mloop_agen.sv
module dma_mloop_agen
  import dma_agen_pkg::*;
#(
  parameter int ACC_BYTES = 4,
  parameter int CITER_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               halt,
  input  logic               mem_to_dev,
  input  logic [31:0]        src_base,
  input  logic [31:0]        dst_base,
  input  logic [15:0]        src_step,
  input  logic [15:0]        dst_step,
  input  logic [31:0]        mloop_word,
  input  logic [31:0]        last_adj,
  input  logic [CITER_W-1:0] iter_count,
  output logic               rd_strobe,
  output logic [31:0]        rd_addr,
  output logic               wr_strobe,
  output logic [31:0]        wr_addr,
  output logic               major_done,
  output logic               busy,
  output logic [CITER_W-1:0] cur_iter
);
  desc_t         desc_q;
  logic          load;
  logic          step;
  logic          minor_end;
  logic          major_end;
  logic [AW-1:0] ml_off;

  assign load = start && !busy && (iter_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_q <= '0;
    else if (load) begin
      desc_q.mem_to_dev <= mem_to_dev;
      desc_q.src_step   <= src_step;
      desc_q.dst_step   <= dst_step;
      desc_q.mloop_word <= mloop_word;
      desc_q.last_adj   <= last_adj;
    end
  end

  assign ml_off = f_mloff(desc_q.mloop_word);

  agen_loop_ctrl #(.ACC_BYTES(ACC_BYTES), .CITER_W(CITER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .halt(halt),
    .load_bytes(f_minor_bytes(mloop_word)), .load_iter(iter_count),
    .busy(busy), .step(step), .minor_end(minor_end), .major_end(major_end),
    .done(major_done), .citer(cur_iter)
  );

  logic [1:0][AW-1:0]    side_base;
  logic [1:0][OFF_W-1:0] side_step;
  logic [1:0]            side_ml_en;
  logic [1:0]            side_last_en;
  logic [1:0][AW-1:0]    side_addr;

  assign side_base    = {dst_base, src_base};
  assign side_step    = {desc_q.dst_step, desc_q.src_step};
  assign side_ml_en   = {f_dst_ml_en(desc_q.mloop_word), f_src_ml_en(desc_q.mloop_word)};
  assign side_last_en = {!desc_q.mem_to_dev, desc_q.mem_to_dev};

  for (genvar g = 0; g < 2; g++) begin : g_side
    agen_addr_unit u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(side_base[g]),
      .step(step), .minor_end(minor_end), .major_end(major_end),
      .acc_off(side_step[g]), .ml_en(side_ml_en[g]), .ml_off(ml_off),
      .last_en(side_last_en[g]), .last_adj(desc_q.last_adj),
      .addr(side_addr[g])
    );
  end

  assign rd_addr   = side_addr[0];
  assign wr_addr   = side_addr[1];
  assign rd_strobe = busy;
  assign wr_strobe = busy;

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt) |=> (!busy && !major_done)); // R10
  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && iter_count == '0) |=> !busy); // R9
  AST_BUSY_START_KEEPS_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(desc_q)); // R9
endmodule

// File: tb/dma_mloop_agen_tb.sv
module dma_mloop_agen_tb;
  localparam int ACC = 4;
  localparam int CW  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, halt = 1'b0, mem_to_dev = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, mloop_word = '0, last_adj = '0;
  logic [15:0] src_step = '0, dst_step = '0;
  logic [CW-1:0] iter_count = '0;
  logic rd_strobe, wr_strobe, major_done, busy;
  logic [31:0] rd_addr, wr_addr;
  logic [CW-1:0] cur_iter;

  always #10 clk = ~clk;

  dma_mloop_agen #(.ACC_BYTES(ACC), .CITER_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .mem_to_dev(mem_to_dev),
    .src_base(src_base), .dst_base(dst_base), .src_step(src_step), .dst_step(dst_step),
    .mloop_word(mloop_word), .last_adj(last_adj), .iter_count(iter_count),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .major_done(major_done), .busy(busy), .cur_iter(cur_iter)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  bit m_busy = 0, m_done = 0, q_m2d = 0;
  int unsigned m_src = 0, m_dst = 0, m_left = 0, q_bytes = 0;
  int m_citer = 0, q_iter = 0, q_soff = 0, q_doff = 0, q_ml = 0, q_last = 0;
  bit q_sen = 0, q_den = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int step16(input logic [15:0] s);
    return int'($signed(s));
  endfunction

  task automatic model_edge();
    if (!m_busy) begin
      m_done = 0;
      if (start && iter_count != 0) begin
        q_sen = mloop_word[31]; q_den = mloop_word[30];
        q_bytes = (q_sen || q_den) ? (mloop_word & 32'h3FF) : mloop_word;
        q_ml = int'($signed(mloop_word[29:10]));
        q_soff = step16(src_step); q_doff = step16(dst_step);
        q_last = int'(last_adj); q_m2d = mem_to_dev; q_iter = int'(iter_count);
        m_busy = 1; m_src = src_base; m_dst = dst_base;
        m_left = q_bytes; m_citer = q_iter;
      end
    end else if (halt) begin
      m_busy = 0; m_done = 0;
    end else begin
      bit fin, maj;
      int ds, dd;
      fin = (m_left <= ACC);
      maj = fin && (m_citer == 1);
      ds = q_soff; dd = q_doff;
      if (fin && q_sen) ds += q_ml;
      if (fin && q_den) dd += q_ml;
      if (maj) begin
        if (q_m2d) ds += q_last; else dd += q_last;
      end
      m_src = m_src + ds; m_dst = m_dst + dd;
      if (fin) begin
        m_left = q_bytes;
        m_citer = maj ? q_iter : m_citer - 1;
      end else m_left = m_left - ACC;
      m_done = maj;
    end
  endtask

  task automatic compare();
    check("R2/R10 busy", busy, m_busy);
    check("R2/R10 rd_strobe", rd_strobe, m_busy);
    check("R2/R10 wr_strobe", wr_strobe, m_busy);
    check("R6 major_done", major_done, m_done);
    if (m_busy) begin
      check("R3/R5/R7/R11 rd_addr", rd_addr, m_src);
      check("R3/R5/R7/R11 wr_addr", wr_addr, m_dst);
      check("R4/R6 cur_iter", cur_iter, m_citer);
    end
  endtask

  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    start = 0;
    compare();
  endtask

  task automatic load_desc(input bit m2d, input logic [31:0] sb, db,
                           input logic [15:0] ss, ds, input logic [31:0] w, la,
                           input int it);
    mem_to_dev = m2d; src_base = sb; dst_base = db; src_step = ss; dst_step = ds;
    mloop_word = w; last_adj = la; iter_count = CW'(it); start = 1;
  endtask

  task automatic stop_run();
    halt = 1; cycle(); halt = 0;
    check("R10 idle after halt", {busy, rd_strobe, wr_strobe, major_done}, 0);
    cycle();
  endtask

  function automatic logic [31:0] ml_word(input bit sen, den, input int off, input int nb);
    logic [19:0] f;
    f = 20'(off);
    return {sen, den, f, 10'(nb)};
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check("R1 reset quiet", {busy, rd_strobe, wr_strobe, major_done}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {busy, rd_strobe, wr_strobe, major_done}, 0);

    // R8: dual FIFO, memory to device
    load_desc(1, 32'h1000, 32'h2000, 16'd4, 16'd4, ml_word(0, 1, -8, 8), -32'sd32, 4);
    cycle();
    check("R2 load src", rd_addr, 32'h1000);
    check("R2 load dst", wr_addr, 32'h2000);
    check("R2 load iter", cur_iter, 4);
    for (int i = 1; i < 8; i++) begin
      cycle();
      check("R8 fifo alternation", wr_addr, (i % 2) ? 32'h2004 : 32'h2000);
    end
    cycle();
    check("R7 ring restart src", rd_addr, 32'h1000);
    check("R6 done pulse", major_done, 1);
    cycle();
    check("R6 done one cycle", major_done, 0);
    stop_run();

    // R8: dual FIFO, device to memory
    load_desc(0, 32'h4000, 32'h8000, 16'd4, 16'd4, ml_word(1, 0, -8, 8), -32'sd16, 2);
    cycle();
    for (int i = 1; i < 6; i++) begin
      cycle();
      check("R8 rx fifo alternation", rd_addr, (i % 2) ? 32'h4004 : 32'h4000);
    end
    stop_run();

    // R11: wrap
    load_desc(1, 32'hFFFF_FFFC, 32'h0000_0002, 16'd4, 16'hFFFC, 32'd16, 32'd0, 3);
    cycle(); cycle();
    check("R11 src wrap", rd_addr, 32'h0);
    check("R11 dst wrap", wr_addr, 32'hFFFF_FFFE);
    // R9: start while busy ignored
    load_desc(0, 32'h5555_0000, 32'h6666_0000, 16'd8, 16'd8, 32'd4, 32'd0, 7);
    cycle();
    check("R9 busy start src", rd_addr, 32'h4);
    check("R9 busy start iter", cur_iter, 3);
    stop_run();

    // R9: zero count ignored
    load_desc(0, 32'h10, 32'h20, 16'd1, 16'd1, 32'd4, 32'd0, 0);
    cycle();
    check("R9 zero count idle", busy, 0);

    // R4: zero byte count, one access per minor loop
    load_desc(0, 32'h100, 32'h200, 16'd0, 16'd4, 32'd0, 32'd64, 2);
    cycle(); cycle();
    check("R4 zero bytes one access", cur_iter, 1);
    cycle();
    check("R4/R7 dst adjusted", wr_addr, 32'h200 + 8 + 64);
    stop_run();

    // random runs
    for (int r = 0; r < 60; r++) begin
      int mode = int'($urandom_range(0, 2));
      logic [31:0] w;
      bit m2d = 1'($urandom_range(0, 1));
      int ss = int'($urandom_range(0, 16)) - 8;
      int ds = int'($urandom_range(0, 16)) - 8;
      if (mode == 0) begin
        w = ml_word(!m2d, m2d, -8, 8);
        if (m2d) ds = 4; else ss = 4;
      end else if (mode == 1) begin
        w = 32'($urandom_range(0, 24));
      end else begin
        w = ml_word(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 64)) - 32, int'($urandom_range(0, 24)));
      end
      load_desc(m2d, $urandom, $urandom, 16'(ss), 16'(ds), w,
                32'(int'($urandom_range(0, 256)) - 128), int'($urandom_range(1, 5)));
      for (int c = 0; c < 40; c++) begin
        if (c == 17) begin
          src_base = $urandom; iter_count = 9; start = 1; // R9 mid-run start
        end
        cycle();
      end
      stop_run();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule